// File: doc/BRIEF.md
# Masked-ID Priority Command Picker

This block sits beside the command scheduler of a memory controller. The scheduler issues commands in snapshots. A snapshot is a batch of accesses that all go in one direction, either read or write. Each time an access issues, the picker scans the pending command entries. It looks for one whose requester ID satisfies either of two programmed priority rules and whose direction equals the current snapshot direction. If such an entry exists, its index is offered as the next access ahead of the ordinary order. If none exists, the scheduler's own choice passes through unchanged.

Each rule has three fields: an enable, an ID and a mask. A mask bit of 1 means the ID bit must match, and a mask bit of 0 makes that bit a don't-care. This lets one rule promote a single requester, or a family of IDs from one master. Both rules come up disabled after reset, so no requester is promoted until software loads a rule.

Top module: `prio_cmd_picker`

## Requirements
- R1: After reset, `prio_hit_o` is 0, `sel_idx_o` is 0 and both rules are disabled, so an issue promotes nothing.
- R2: A rule with mask bits at 0 ignores those ID bits. With ID 7234 and mask 0xFFFE, IDs 7234 and 7235 qualify and 7236 does not.
- R3: A rule whose mask is all ones qualifies only the exact programmed ID.
- R4: A disabled rule qualifies no entry, even when its mask is 0.
- R5: An entry qualifies only if its direction bit equals `snap_dir`, where 0 means read and 1 means write. An entry with `ent_valid_i` bit at 0 never qualifies.
- R6: An entry qualifies when it satisfies either rule 0 or rule 1.
- R7: When several entries qualify, the lowest index is selected.
- R8: When no entry qualifies at an issue, `prio_hit_o` is 0 and `sel_idx_o` equals the `norm_idx_i` value that was sampled at that issue.
- R9: The result of an issue appears in the cycle after `issue_i` is high. In a cycle that follows no issue, `prio_hit_o` is 0.
- R10: A rule write and an issue in the same cycle: the issue is judged with the rule settings held before that write, and the new settings apply from the next issue.
- R11: A configuration write with `cfg_we` set loads `cfg_en`, `cfg_id` and `cfg_mask` into the rule numbered by `cfg_sel`. The other rule is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Rule write strobe |
| cfg_sel | input | SEL_W | Rule number to write |
| cfg_en | input | 1 | Enable value for the written rule |
| cfg_id | input | ID_W | Priority ID for the written rule |
| cfg_mask | input | ID_W | Compare mask for the written rule (1 = compare bit) |
| snap_dir | input | 1 | Current snapshot direction (0 read, 1 write) |
| issue_i | input | 1 | An access issued this cycle; evaluate the entries |
| norm_idx_i | input | IDX_W | Scheduler's ordinary next index |
| ent_valid_i | input | NUM_ENT | Entry holds a pending command |
| ent_dir_i | input | NUM_ENT | Entry direction (0 read, 1 write) |
| ent_id_i | input | NUM_ENT*ID_W | Entry requester IDs, entry k at bits k*ID_W upward |
| prio_hit_o | output | 1 | A promoted entry was found at the last issue |
| sel_idx_o | output | IDX_W | Next access index (promoted or ordinary) |

## Verification
Two events can land on the same clock edge: a rule reload and the search triggered by an issue. The bench provokes this by raising `cfg_we` and `issue_i` in the same cycle. In one case the write disables a rule that currently promotes a pending entry. In the other it reloads a rule with a new ID. The scoreboard predicts the issue result from the rule set held before the write and then applies the write to its own model. The next issue must then reflect the new setting.

// File: rtl/pcp_pkg.sv
package pcp_pkg;

   typedef enum logic {
      DIR_RD = 1'b0,
      DIR_WR = 1'b1
   } pcp_dir_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pcp_rule_reg.sv
module pcp_rule_reg #(
   parameter int ID_W     = 16,
   parameter int SEL_W    = 1,
   parameter int RULE_IDX = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic             cfg_en,
   input  logic [ID_W-1:0]  cfg_id,
   input  logic [ID_W-1:0]  cfg_mask,
   output logic             rule_en,
   output logic [ID_W-1:0]  rule_id,
   output logic [ID_W-1:0]  rule_mask
);

   logic wr_this;
   assign wr_this = cfg_we && (cfg_sel == SEL_W'(RULE_IDX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rule_en   <= 1'b0;
         rule_id   <= '0;
         rule_mask <= '0;
      end else if (wr_this) begin
         rule_en   <= cfg_en;
         rule_id   <= cfg_id;
         rule_mask <= cfg_mask;
      end
   end

   // R11
   rule_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_this |=> (rule_en == $past(cfg_en)) && (rule_id == $past(cfg_id))
                  && (rule_mask == $past(cfg_mask)));

   // R11
   rule_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_this |=> $stable(rule_en) && $stable(rule_id) && $stable(rule_mask));

endmodule

// File: rtl/pcp_entry_match.sv
module pcp_entry_match #(
   parameter int ID_W      = 16,
   parameter int NUM_RULES = 2
) (
   input  logic                      ent_valid,
   input  logic                      ent_dir,
   input  logic                      snap_dir,
   input  logic [ID_W-1:0]           ent_id,
   input  logic [NUM_RULES-1:0]      rule_en,
   input  logic [NUM_RULES*ID_W-1:0] rule_id,
   input  logic [NUM_RULES*ID_W-1:0] rule_mask,
   output logic                      qual
);

   logic [NUM_RULES-1:0] rule_hit;

   for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
      logic [ID_W-1:0] diff;
      assign diff        = (ent_id ^ rule_id[r*ID_W +: ID_W]) & rule_mask[r*ID_W +: ID_W];
      assign rule_hit[r] = rule_en[r] && (diff == '0);
   end

   assign qual = ent_valid && (ent_dir == snap_dir) && (|rule_hit);

endmodule

// File: rtl/pcp_oldest_pick.sv
module pcp_oldest_pick #(
   parameter int NUM_ENT = 8,
   parameter int IDX_W   = 3,
   parameter bit ONEHOT  = 1'b1
) (
   input  logic [NUM_ENT-1:0] req,
   output logic               found,
   output logic [IDX_W-1:0]   idx
);

   assign found = |req;

   if (ONEHOT) begin : g_onehot
      logic [NUM_ENT-1:0] lowest;
      assign lowest = req & (~req + NUM_ENT'(1));
      always_comb begin
         idx = '0;
         for (int k = 0; k < NUM_ENT; k++) begin
            if (lowest[k]) idx = idx | IDX_W'(k);
         end
      end
   end else begin : g_scan
      always_comb begin
         idx = '0;
         for (int k = NUM_ENT - 1; k >= 0; k--) begin
            if (req[k]) idx = IDX_W'(k);
         end
      end
   end

endmodule

// File: rtl/prio_cmd_picker.sv
module prio_cmd_picker #(
   parameter int NUM_ENT    = 8,
   parameter int ID_W       = 16,
   parameter int NUM_RULES  = 2,
   parameter bit PICK_ONEHOT = 1'b1,
   localparam int IDX_W     = pcp_pkg::idx_width(NUM_ENT),
   localparam int SEL_W     = pcp_pkg::idx_width(NUM_RULES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [SEL_W-1:0]        cfg_sel,
   input  logic                    cfg_en,
   input  logic [ID_W-1:0]         cfg_id,
   input  logic [ID_W-1:0]         cfg_mask,
   input  logic                    snap_dir,
   input  logic                    issue_i,
   input  logic [IDX_W-1:0]        norm_idx_i,
   input  logic [NUM_ENT-1:0]      ent_valid_i,
   input  logic [NUM_ENT-1:0]      ent_dir_i,
   input  logic [NUM_ENT*ID_W-1:0] ent_id_i,
   output logic                    prio_hit_o,
   output logic [IDX_W-1:0]        sel_idx_o
);

   if (NUM_ENT < 1) begin : g_bad_ent
      $error("NUM_ENT must be at least 1");
   end
   if (NUM_RULES < 1) begin : g_bad_rules
      $error("NUM_RULES must be at least 1");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("ID_W must be at least 1");
   end

   logic [NUM_RULES-1:0]      rule_en;
   logic [NUM_RULES*ID_W-1:0] rule_id;
   logic [NUM_RULES*ID_W-1:0] rule_mask;

   for (genvar r = 0; r < NUM_RULES; r++) begin : g_rules
      pcp_rule_reg #(
         .ID_W     (ID_W),
         .SEL_W    (SEL_W),
         .RULE_IDX (r)
      ) u_rule (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_we    (cfg_we),
         .cfg_sel   (cfg_sel),
         .cfg_en    (cfg_en),
         .cfg_id    (cfg_id),
         .cfg_mask  (cfg_mask),
         .rule_en   (rule_en[r]),
         .rule_id   (rule_id[r*ID_W +: ID_W]),
         .rule_mask (rule_mask[r*ID_W +: ID_W])
      );
   end

   logic [NUM_ENT-1:0] qual_vec;

   for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
      pcp_entry_match #(
         .ID_W      (ID_W),
         .NUM_RULES (NUM_RULES)
      ) u_match (
         .ent_valid (ent_valid_i[e]),
         .ent_dir   (ent_dir_i[e]),
         .snap_dir  (snap_dir),
         .ent_id    (ent_id_i[e*ID_W +: ID_W]),
         .rule_en   (rule_en),
         .rule_id   (rule_id),
         .rule_mask (rule_mask),
         .qual      (qual_vec[e])
      );
   end

   logic             pick_found;
   logic [IDX_W-1:0] pick_idx;

   pcp_oldest_pick #(
      .NUM_ENT (NUM_ENT),
      .IDX_W   (IDX_W),
      .ONEHOT  (PICK_ONEHOT)
   ) u_pick (
      .req   (qual_vec),
      .found (pick_found),
      .idx   (pick_idx)
   );

   logic [NUM_ENT-1:0] below_pick;
   assign below_pick = (NUM_ENT'(1) << pick_idx) - NUM_ENT'(1);

   // R7
   lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pick_found |-> qual_vec[pick_idx] && ((qual_vec & below_pick) == '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio_hit_o <= 1'b0;
         sel_idx_o  <= '0;
      end else if (issue_i) begin
         prio_hit_o <= pick_found;
         sel_idx_o  <= pick_found ? pick_idx : norm_idx_i;
      end else begin
         prio_hit_o <= 1'b0;
      end
   end

   // R9
   hit_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prio_hit_o |-> $past(issue_i));

   // R9
   promote_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && (|qual_vec)) |=> prio_hit_o);

   // R8
   fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !(|qual_vec)) |=> !prio_hit_o && (sel_idx_o == $past(norm_idx_i)));

endmodule

// File: tb/tb_prio_cmd_picker.sv
module tb_prio_cmd_picker;

   localparam int CLK_PERIOD = 10;
   localparam int N  = 8;
   localparam int IW = 16;
   localparam int XW = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [0:0]      cfg_sel = '0;
   logic            cfg_en = 1'b0;
   logic [IW-1:0]   cfg_id = '0;
   logic [IW-1:0]   cfg_mask = '0;
   logic            snap_dir = 1'b0;
   logic            issue_i = 1'b0;
   logic [XW-1:0]   norm_idx_i = '0;
   logic [N-1:0]    ent_valid_i = '0;
   logic [N-1:0]    ent_dir_i = '0;
   logic [N*IW-1:0] ent_id_i = '0;
   logic            prio_hit_o;
   logic [XW-1:0]   sel_idx_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   prio_cmd_picker dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_en(cfg_en), .cfg_id(cfg_id), .cfg_mask(cfg_mask),
      .snap_dir(snap_dir), .issue_i(issue_i), .norm_idx_i(norm_idx_i),
      .ent_valid_i(ent_valid_i), .ent_dir_i(ent_dir_i), .ent_id_i(ent_id_i),
      .prio_hit_o(prio_hit_o), .sel_idx_o(sel_idx_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // bench model state
   bit          m_en   [2];
   bit [IW-1:0] m_id   [2];
   bit [IW-1:0] m_mask [2];
   bit          t_vld  [N];
   bit          t_dir  [N];
   bit [IW-1:0] t_id   [N];

   // pending stimulus
   bit          p_snap;
   bit [XW-1:0] p_norm;
   bit          p_sel;
   bit          p_en;
   bit [IW-1:0] p_id;
   bit [IW-1:0] p_mask;

   // scoreboard
   int    q_hit [$];
   int    q_idx [$];
   string q_tag [$];

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic void clear_ents();
      for (int i = 0; i < N; i++) begin
         t_vld[i] = 1'b0;
         t_dir[i] = 1'b0;
         t_id[i]  = '0;
      end
   endfunction

   function automatic void put_ent(input int i, input bit [IW-1:0] id, input bit dir);
      t_vld[i] = 1'b1;
      t_id[i]  = id;
      t_dir[i] = dir;
   endfunction

   function automatic void rule(input bit sel, input bit en, input bit [IW-1:0] id, input bit [IW-1:0] mask);
      p_sel = sel; p_en = en; p_id = id; p_mask = mask;
   endfunction

   task automatic go(input bit iss, input bit wr, input string tag);
      bit h;
      int ix;
      @(negedge clk);
      issue_i    = iss;
      cfg_we     = wr;
      cfg_sel    = p_sel;
      cfg_en     = p_en;
      cfg_id     = p_id;
      cfg_mask   = p_mask;
      snap_dir   = p_snap;
      norm_idx_i = p_norm;
      for (int i = 0; i < N; i++) begin
         ent_valid_i[i]        = t_vld[i];
         ent_dir_i[i]          = t_dir[i];
         ent_id_i[i*IW +: IW]  = t_id[i];
      end
      if (iss) begin
         h  = 1'b0;
         ix = int'(p_norm);
         for (int i = 0; i < N; i++) begin
            if (!h && t_vld[i] && (t_dir[i] == p_snap)) begin
               for (int r = 0; r < 2; r++) begin
                  if (m_en[r] && (((t_id[i] ^ m_id[r]) & m_mask[r]) == '0)) begin
                     h  = 1'b1;
                     ix = i;
                  end
               end
            end
         end
         q_hit.push_back(int'(h));
         q_idx.push_back(ix);
         q_tag.push_back(tag);
      end
      if (wr) begin
         m_en[p_sel]   = p_en;
         m_id[p_sel]   = p_id;
         m_mask[p_sel] = p_mask;
      end
   endtask

   task automatic idle();
      @(negedge clk);
      issue_i = 1'b0;
      cfg_we  = 1'b0;
   endtask

   // monitor
   bit iss_d = 1'b0;
   always @(posedge clk) iss_d <= rst_n && issue_i;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (iss_d) begin
            if (q_hit.size() == 0) begin
               check("scoreboard empty", 0, 1);
            end else begin
               string t;
               int eh;
               int ei;
               t  = q_tag.pop_front();
               eh = q_hit.pop_front();
               ei = q_idx.pop_front();
               check({t, " hit"}, int'(prio_hit_o), eh);
               check({t, " idx"}, int'(sel_idx_o), ei);
            end
         end else begin
            check("R9 no-issue hit low", int'(prio_hit_o), 0);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < 2; r++) begin
         m_en[r] = 1'b0; m_id[r] = '0; m_mask[r] = '0;
      end
      clear_ents();
      p_snap = pcp_pkg::DIR_RD;
      p_norm = 3'd6;
      rule(1'b0, 1'b0, '0, '0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset hit", int'(prio_hit_o), 0);
      check("R1 reset idx", int'(sel_idx_o), 0);

      // R1 / R4: rules disabled after reset, zero masks promote nothing
      put_ent(1, 16'd7234, pcp_pkg::DIR_RD);
      put_ent(4, 16'd99, pcp_pkg::DIR_RD);
      go(1'b1, 1'b0, "R1 disabled after reset");
      idle();

      // R3: exact match with all-ones mask
      rule(1'b0, 1'b1, 16'd7234, 16'hFFFF);
      go(1'b0, 1'b1, "cfg");
      clear_ents();
      put_ent(2, 16'd7235, pcp_pkg::DIR_RD);
      put_ent(5, 16'd7234, pcp_pkg::DIR_RD);
      p_norm = 3'd0;
      go(1'b1, 1'b0, "R3 exact id");
      clear_ents();
      put_ent(2, 16'd7235, pcp_pkg::DIR_RD);
      p_norm = 3'd3;
      go(1'b1, 1'b0, "R3 near id rejected");
      idle();

      // R2: mask bit 0 is don't-care
      rule(1'b0, 1'b1, 16'd7234, 16'hFFFE);
      go(1'b0, 1'b1, "cfg");
      go(1'b1, 1'b0, "R2 7235 promoted");
      clear_ents();
      put_ent(3, 16'd7236, pcp_pkg::DIR_RD);
      put_ent(6, 16'd7234, pcp_pkg::DIR_RD);
      go(1'b1, 1'b0, "R2 7234 promoted 7236 not");
      clear_ents();
      put_ent(3, 16'd7236, pcp_pkg::DIR_RD);
      p_norm = 3'd7;
      go(1'b1, 1'b0, "R2 7236 rejected");
      idle();

      // R5: direction must match snapshot; invalid entries ignored
      clear_ents();
      put_ent(4, 16'd7234, pcp_pkg::DIR_WR);
      p_norm = 3'd2;
      go(1'b1, 1'b0, "R5 direction mismatch");
      p_snap = pcp_pkg::DIR_WR;
      go(1'b1, 1'b0, "R5 direction match");
      clear_ents();
      put_ent(0, 16'd7234, pcp_pkg::DIR_WR);
      t_vld[0] = 1'b0;
      go(1'b1, 1'b0, "R5 invalid ignored");
      idle();

      // R6 / R11: second rule, first rule kept
      rule(1'b1, 1'b1, 16'h0100, 16'hFF00);
      go(1'b0, 1'b1, "cfg");
      clear_ents();
      put_ent(5, 16'h01AB, pcp_pkg::DIR_WR);
      go(1'b1, 1'b0, "R6 rule1 match");
      put_ent(2, 16'd7235, pcp_pkg::DIR_WR);
      go(1'b1, 1'b0, "R11 rule0 kept after rule1 write");
      idle();

      // R7: several qualifiers, lowest index wins (back-to-back issues, R9)
      clear_ents();
      put_ent(0, 16'd7234, pcp_pkg::DIR_RD);
      put_ent(1, 16'h0155, pcp_pkg::DIR_WR);
      put_ent(4, 16'd7234, pcp_pkg::DIR_WR);
      put_ent(6, 16'd7235, pcp_pkg::DIR_WR);
      go(1'b1, 1'b0, "R7 lowest of several");
      t_vld[1] = 1'b0;
      go(1'b1, 1'b0, "R7 R9 next after removal");
      t_vld[4] = 1'b0;
      go(1'b1, 1'b0, "R7 R9 last qualifier");
      idle();
      idle();

      // R10: rule write and issue in the same cycle
      rule(1'b0, 1'b0, 16'd7234, 16'hFFFE);
      p_norm = 3'd1;
      go(1'b1, 1'b1, "R10 old rule0 still applies");
      go(1'b1, 1'b0, "R10 new rule0 disabled");
      rule(1'b1, 1'b1, 16'd7235, 16'hFFFF);
      go(1'b1, 1'b1, "R10 old rule1 id used");
      go(1'b1, 1'b0, "R10 new rule1 id used");
      idle();

      // R4: enabled zero mask matches all, disabled zero mask matches none
      rule(1'b1, 1'b0, '0, '0);
      go(1'b0, 1'b1, "cfg");
      rule(1'b0, 1'b1, 16'h1234, '0);
      go(1'b0, 1'b1, "cfg");
      clear_ents();
      put_ent(3, 16'hBEEF, pcp_pkg::DIR_WR);
      put_ent(7, 16'h0001, pcp_pkg::DIR_WR);
      go(1'b1, 1'b0, "R4 enabled zero mask matches any");
      rule(1'b0, 1'b0, 16'h1234, '0);
      go(1'b0, 1'b1, "cfg");
      p_norm = 3'd5;
      go(1'b1, 1'b0, "R4 disabled zero mask matches none");
      idle();
      idle();

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule